// File: doc/BRIEF.md
# x86 Operating Mode Tracker

This block follows the execution mode of an x86-style core and its current privilege level (CPL). The core reports architectural events to it as one-cycle strobes: a control-register write that sets or clears the protection-enable bit, a return-from-interrupt carrying the flags image and code privilege it popped, a flags pop, a task switch carrying the loaded flags image and privilege, and an interrupt or exception entry carrying the decoded attributes of the gate and of its target segment. The block answers with the current mode, the CPL, the virtual-8086 flag and a one-cycle fault pulse.

The virtual-8086 rules are enforced here. The core can enter that mode only by a return at CPL 0 that restores the flag, or by a task switch that loads it. A flags pop never touches the flag. The core can leave that mode only through an interrupt or exception that uses an acceptable gate. Every state change and every fault appears one clock after the strobe.

Top module: `x86_mode_tracker`

## Requirements
- R1: After reset (active-low `rst_n`), `mode` is 2'b00 (real), `cpl` is 0, `vm` is 0 and `fault` is 0.
- R2: In real mode, a CR0 write with `cr0_pe`=1 moves to protected mode (`mode`=2'b01) with CPL 0; with `cr0_pe`=0 the block stays in real mode.
- R3: In protected mode, a CR0 write with `cr0_pe`=0 returns to real mode with CPL 0, and one with `cr0_pe`=1 keeps mode and CPL. CR0 writes are ignored in virtual-8086 mode.
- R4: In protected mode at CPL 0, an IRET with `iret_vm`=1 enters virtual-8086 mode (`mode`=2'b10, `vm`=1) with CPL 3.
- R5: In protected mode, any other IRET leaves `vm` at 0 and sets CPL to `iret_cpl` only when that is numerically not lower than the current CPL. IRET has no effect in real or virtual-8086 mode.
- R6: In protected or virtual-8086 mode, a task switch sets `vm` to `tsw_vm`. With `tsw_vm`=1 the CPL becomes 3; otherwise the mode is protected and the CPL becomes `tsw_cpl`.
- R7: POPF never changes `mode`, `cpl`, `vm` or `fault`, in any mode.
- R8: Whenever `mode` is virtual-8086, `cpl` reads 3.
- R9: In virtual-8086 mode, an interrupt entry through a legal gate clears `vm`, gives protected mode with CPL 0, and raises no fault. The legal gates are `gate_kind` 0 (32-bit interrupt gate) or 1 (32-bit trap gate) with `tgt_conf`=0 and `tgt_dpl`=0, or `gate_kind` 2 (32-bit TSS).
- R10: In virtual-8086 mode, an interrupt entry through any other gate (including `gate_kind` 3, any other gate) pulses `fault` for exactly one cycle and leaves mode and CPL unchanged.
- R11: For a software interrupt (`int_sw`=1) in protected or virtual-8086 mode, a CPL numerically greater than `gate_dpl` pulses `fault` and leaves mode and CPL unchanged.
- R12: In real mode, interrupt entries, IRETs and task switches change nothing and never fault.
- R13: In protected mode, a permitted interrupt entry sets the CPL to `tgt_dpl`, except when the target is conforming (`tgt_conf`=1) and the gate is not a TSS, in which case the CPL is kept.
- R14: When strobes coincide, only one acts, chosen in this order: interrupt entry, then task switch, then IRET, then CR0 write. The lower-priority strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr0_wr | input | 1 | CR0 write strobe |
| cr0_pe | input | 1 | Protection-enable value written |
| iret_ev | input | 1 | IRET strobe |
| iret_vm | input | 1 | VM bit of popped flags image |
| iret_cpl | input | 2 | Privilege of popped return code selector |
| popf_ev | input | 1 | Flags pop strobe |
| tsw_ev | input | 1 | Task switch strobe |
| tsw_vm | input | 1 | VM bit of the loaded flags image |
| tsw_cpl | input | 2 | Privilege of the new task's code |
| int_ev | input | 1 | Interrupt/exception entry strobe |
| int_sw | input | 1 | Entry caused by a software interrupt instruction |
| gate_kind | input | 2 | 0 int32, 1 trap32, 2 TSS32, 3 other |
| gate_dpl | input | 2 | Gate descriptor privilege |
| tgt_conf | input | 1 | Target code segment is conforming |
| tgt_dpl | input | 2 | Target code segment privilege |
| mode | output | 2 | 0 real, 1 protected, 2 virtual-8086 |
| cpl | output | 2 | Current privilege level |
| vm | output | 1 | Virtual-8086 flag |
| fault | output | 1 | One-cycle protection fault pulse |

## Verification
The properties that check how a strobe acts on its own (flags pop, CR0 write in virtual-8086 mode) require the other strobes to be low in that cycle. The entry and exit properties assume that the descriptor attribute inputs are valid whenever their strobe is high. The stimulus builds each starting state (real, protected at every CPL, virtual-8086) after a fresh reset. It then fires one strobe, or a deliberate pair for the priority case, and sweeps every combination of that event's attribute inputs.

// File: rtl/x86_mode_tracker.sv
module x86_mode_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cr0_wr,
  input  logic       cr0_pe,
  input  logic       iret_ev,
  input  logic       iret_vm,
  input  logic [1:0] iret_cpl,
  input  logic       popf_ev,
  input  logic       tsw_ev,
  input  logic       tsw_vm,
  input  logic [1:0] tsw_cpl,
  input  logic       int_ev,
  input  logic       int_sw,
  input  logic [1:0] gate_kind,
  input  logic [1:0] gate_dpl,
  input  logic       tgt_conf,
  input  logic [1:0] tgt_dpl,
  output logic [1:0] mode,
  output logic [1:0] cpl,
  output logic       vm,
  output logic       fault
);
  localparam logic [1:0] MODE_REAL = 2'd0;
  localparam logic [1:0] MODE_PROT = 2'd1;
  localparam logic [1:0] MODE_V86  = 2'd2;
  localparam logic [1:0] GK_INT32  = 2'd0;
  localparam logic [1:0] GK_TRAP32 = 2'd1;
  localparam logic [1:0] GK_TSS32  = 2'd2;

  logic       pe_q, vm_q, fault_q;
  logic [1:0] cpl_q;
  logic       pe_n, vm_n;
  logic [1:0] cpl_n;

  wire in_prot = pe_q & ~vm_q;
  wire priv_ok = ~int_sw | (cpl_q <= gate_dpl);
  wire exit_ok = ((gate_kind == GK_INT32 || gate_kind == GK_TRAP32) && !tgt_conf && tgt_dpl == 2'd0)
               || gate_kind == GK_TSS32;
  wire int_bad = int_ev & pe_q & (~priv_ok | (vm_q & ~exit_ok));

  always_comb begin
    pe_n  = pe_q;
    vm_n  = vm_q;
    cpl_n = cpl_q;
    if (int_ev) begin
      if (pe_q && !int_bad) begin
        if (vm_q) begin
          vm_n  = 1'b0;
          cpl_n = 2'd0;
        end else if (gate_kind == GK_TSS32 || !tgt_conf) begin
          cpl_n = tgt_dpl;
        end
      end
    end else if (tsw_ev) begin
      if (pe_q) begin
        vm_n  = tsw_vm;
        cpl_n = tsw_vm ? 2'd3 : tsw_cpl;
      end
    end else if (iret_ev) begin
      if (in_prot) begin
        if (iret_vm && cpl_q == 2'd0) begin
          vm_n  = 1'b1;
          cpl_n = 2'd3;
        end else if (iret_cpl >= cpl_q) begin
          cpl_n = iret_cpl;
        end
      end
    end else if (cr0_wr) begin
      if (!vm_q) begin
        pe_n = cr0_pe;
        if (!cr0_pe) cpl_n = 2'd0;
      end
    end else if (popf_ev) begin
      vm_n = vm_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q    <= 1'b0;
      vm_q    <= 1'b0;
      cpl_q   <= 2'd0;
      fault_q <= 1'b0;
    end else begin
      pe_q    <= pe_n;
      vm_q    <= vm_n;
      cpl_q   <= cpl_n;
      fault_q <= int_bad;
    end
  end

  assign mode  = !pe_q ? MODE_REAL : (vm_q ? MODE_V86 : MODE_PROT);
  assign cpl   = cpl_q;
  assign vm    = vm_q;
  assign fault = fault_q;
endmodule

module x86_mode_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cr0_wr,
  input logic       iret_ev,
  input logic       popf_ev,
  input logic       tsw_ev,
  input logic       int_ev,
  input logic [1:0] mode,
  input logic [1:0] cpl,
  input logic       fault
);
  wire others = int_ev | tsw_ev | iret_ev | cr0_wr;

  AST_V86_CPL3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> cpl == 2'd3); // R8
  AST_POPF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    popf_ev && !others |=> $stable(mode) && $stable(cpl)); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(mode) && $stable(cpl)); // R10
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ev |=> !fault); // R10
  AST_REAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 |=> !fault); // R12
  AST_V86_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) ##1 (mode == 2'd2) |-> $past(tsw_ev || (iret_ev && cpl == 2'd0))); // R4
  AST_V86_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 && int_ev |=> (mode == 2'd2 && fault) || (mode == 2'd1 && cpl == 2'd0 && !fault)); // R9
  AST_CR0_IN_V86: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 && cr0_wr && !(int_ev | tsw_ev | iret_ev) |=> mode == 2'd2); // R3
endmodule

bind x86_mode_tracker x86_mode_tracker_chk u_chk (.*);

// File: tb/sim_x86_mode_tracker.sv
module sim_x86_mode_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cr0_wr = 0, cr0_pe = 0, iret_ev = 0, iret_vm = 0, popf_ev = 0;
  logic tsw_ev = 0, tsw_vm = 0, int_ev = 0, int_sw = 0, tgt_conf = 0;
  logic [1:0] iret_cpl = 0, tsw_cpl = 0, gate_kind = 0, gate_dpl = 0, tgt_dpl = 0;
  logic [1:0] mode, cpl;
  logic vm, fault;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  x86_mode_tracker u0 (.clk(clk), .rst_n(rst_n), .cr0_wr(cr0_wr), .cr0_pe(cr0_pe),
    .iret_ev(iret_ev), .iret_vm(iret_vm), .iret_cpl(iret_cpl), .popf_ev(popf_ev),
    .tsw_ev(tsw_ev), .tsw_vm(tsw_vm), .tsw_cpl(tsw_cpl), .int_ev(int_ev), .int_sw(int_sw),
    .gate_kind(gate_kind), .gate_dpl(gate_dpl), .tgt_conf(tgt_conf), .tgt_dpl(tgt_dpl),
    .mode(mode), .cpl(cpl), .vm(vm), .fault(fault));

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk4(string tag, int em, int ec, int ef);
    chk(tag, "mode", mode, em);
    chk(tag, "cpl", cpl, ec);
    chk(tag, "vm", vm, em == 2 ? 1 : 0);
    chk(tag, "fault", fault, ef);
  endtask

  task automatic clr();
    cr0_wr = 0; iret_ev = 0; popf_ev = 0; tsw_ev = 0; int_ev = 0;
  endtask

  task automatic fire();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic do_reset();
    rst_n = 0;
    clr();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // states: 0 real, 1..4 protected at CPL 0..3, 5 virtual-8086
  task automatic goto_state(int s);
    do_reset();
    if (s >= 1) begin cr0_wr = 1; cr0_pe = 1; fire(); end
    if (s >= 2 && s <= 4) begin iret_ev = 1; iret_vm = 0; iret_cpl = 2'(s - 1); fire(); end
    if (s == 5) begin iret_ev = 1; iret_vm = 1; iret_cpl = 0; fire(); end
  endtask

  function automatic int smode(int s);
    return s == 0 ? 0 : (s == 5 ? 2 : 1);
  endfunction

  function automatic int scpl(int s);
    return s == 0 ? 0 : (s == 5 ? 3 : s - 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk4("R1", 0, 0, 0);

    // state setup itself: R8 virtual-8086 reads CPL 3
    for (int s = 0; s < 6; s++) begin
      goto_state(s);
      chk4(s == 5 ? "R8" : "R2", smode(s), scpl(s), 0);
    end

    // CR0 writes
    for (int s = 0; s < 6; s++)
      for (int p = 0; p < 2; p++) begin
        int em, ec;
        goto_state(s);
        cr0_wr = 1; cr0_pe = p[0]; fire();
        em = smode(s); ec = scpl(s);
        if (em == 0) begin em = p; ec = 0; end
        else if (em == 1 && p == 0) begin em = 0; ec = 0; end
        chk4(s == 0 ? "R2" : "R3", em, ec, 0);
      end

    // IRET
    for (int s = 0; s < 6; s++)
      for (int v = 0; v < 2; v++)
        for (int p = 0; p < 4; p++) begin
          int em, ec;
          string tag;
          goto_state(s);
          iret_ev = 1; iret_vm = v[0]; iret_cpl = 2'(p); fire();
          em = smode(s); ec = scpl(s); tag = "R5";
          if (em == 0) tag = "R12";
          else if (em == 1) begin
            if (v == 1 && ec == 0) begin em = 2; ec = 3; tag = "R4"; end
            else if (p >= ec) ec = p;
          end
          chk4(tag, em, ec, 0);
        end

    // task switch
    for (int s = 0; s < 6; s++)
      for (int v = 0; v < 2; v++)
        for (int p = 0; p < 4; p++) begin
          int em, ec;
          goto_state(s);
          tsw_ev = 1; tsw_vm = v[0]; tsw_cpl = 2'(p); fire();
          em = smode(s); ec = scpl(s);
          if (em != 0) begin em = v ? 2 : 1; ec = v ? 3 : p; end
          chk4(s == 0 ? "R12" : "R6", em, ec, 0);
        end

    // POPF
    for (int s = 0; s < 6; s++) begin
      goto_state(s);
      popf_ev = 1; fire();
      chk4("R7", smode(s), scpl(s), 0);
    end

    // interrupt entry, full attribute sweep
    for (int s = 0; s < 6; s++)
      for (int k = 0; k < 4; k++)
        for (int gd = 0; gd < 4; gd++)
          for (int cf = 0; cf < 2; cf++)
            for (int td = 0; td < 4; td++)
              for (int sw = 0; sw < 2; sw++) begin
                int em, ec, ef;
                string tag;
                goto_state(s);
                int_ev = 1; gate_kind = 2'(k); gate_dpl = 2'(gd);
                tgt_conf = cf[0]; tgt_dpl = 2'(td); int_sw = sw[0];
                fire();
                em = smode(s); ec = scpl(s); ef = 0; tag = "R12";
                if (em == 1) begin
                  if (sw == 1 && ec > gd) begin ef = 1; tag = "R11"; end
                  else begin
                    tag = "R13";
                    if (k == 2 || cf == 0) ec = td;
                  end
                end else if (em == 2) begin
                  if (sw == 1 && gd < 3) begin ef = 1; tag = "R11"; end
                  else if (!((k < 2 && cf == 0 && td == 0) || k == 2)) begin ef = 1; tag = "R10"; end
                  else begin em = 1; ec = 0; tag = "R9"; end
                end
                chk4(tag, em, ec, ef);
                @(negedge clk);
                chk("R10", "fault pulse end", fault, 0);
              end

    // priority: interrupt beats CR0 write in protected mode
    goto_state(1);
    int_ev = 1; int_sw = 0; gate_kind = 0; tgt_conf = 0; tgt_dpl = 2;
    cr0_wr = 1; cr0_pe = 0; fire();
    chk4("R14", 1, 2, 0);
    // priority: task switch (ignored in real mode) beats CR0 write
    goto_state(0);
    tsw_ev = 1; tsw_vm = 0; tsw_cpl = 0; cr0_wr = 1; cr0_pe = 1; fire();
    chk4("R14", 0, 0, 0);
    // priority: task switch beats IRET in protected CPL 0
    goto_state(1);
    tsw_ev = 1; tsw_vm = 0; tsw_cpl = 1; iret_ev = 1; iret_vm = 1; iret_cpl = 0; fire();
    chk4("R14", 1, 1, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule